// File: doc/BRIEF.md
# I2C Status Flag and Interrupt Unit

This block keeps the status flags of an I2C controller and drives two level interrupt lines: one for bus events and one for bus errors. The bus engine next to it sends single-cycle pulses. These pulses report a sent start, a sent address, a finished byte, an empty transmit buffer, a full receive buffer, an acknowledge failure, a lost arbitration and a bus error. The engine also reports each detected START and STOP condition, and the unit uses these to track a bus-busy bit.

Software sees four word registers through a simple strobe port. `reg_addr` selects the register: 0 is status word 1, 1 is status word 2, 2 is the control word and 3 is the data byte. Most flags are cleared as a side effect of register access sequences. No clear register exists. Error flags are cleared by writing zero to their bit positions.

Top module: `i2c_stat_irq`

## Requirements
- R1: After reset all flags, the control word, the busy bit, `tx_byte` and both interrupt lines read 0.
- R2: Each event pulse sets its flag in status word 1: start sent bit0, address sent bit1, byte finished bit2, RX full bit6, TX empty bit7, bus error bit8, arbitration lost bit9, acknowledge failure bit10.
- R3: `irq_event` is 1 in the second cycle after start-sent, address-sent or byte-finished is set while control bit9 is 1. It falls in the cycle after the flag or the enable clears.
- R4: TX empty and RX full drive `irq_event` only while control bit10 is also 1.
- R5: `irq_error` follows the OR of the three error flags, gated by control bit8, with the same one-cycle register delay as R3.
- R6: A write to status word 1 clears each error flag whose bit is 0 in the written data. A 1 leaves the flag unchanged. The write does not touch the other flags.
- R7: Address-sent clears when a status word 2 read immediately follows a status word 1 read, with no other register access in between. A status word 2 read alone does not clear it.
- R8: Start-sent clears when a data write immediately follows a status word 1 read. A data write alone does not clear it.
- R9: A data write clears TX empty and byte-finished. A data read clears RX full and byte-finished, and it returns `rx_byte` in bits 7:0.
- R10: Status word 2 bit1 is the busy bit. A START pulse sets it and a STOP pulse clears it.
- R11: An event pulse that arrives in the same cycle as an access that would clear its flag leaves the flag set.
- R12: The control word reads back bits 10:8 as written. A data write presents the written byte on `tx_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start_sent | input | 1 | Pulse: start condition sent |
| ev_addr_sent | input | 1 | Pulse: address phase done |
| ev_byte_done | input | 1 | Pulse: byte transfer finished |
| ev_tx_empty | input | 1 | Pulse: transmit buffer empty |
| ev_rx_full | input | 1 | Pulse: receive buffer holds a byte |
| ev_ack_fail | input | 1 | Pulse: acknowledge failure |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_bus_err | input | 1 | Pulse: misplaced START/STOP |
| bus_start_det | input | 1 | Pulse: START seen on the bus |
| bus_stop_det | input | 1 | Pulse: STOP seen on the bus |
| rx_byte | input | 8 | Received byte from the engine |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| tx_byte | output | 8 | Byte last written to the data register |
| irq_event | output | 1 | Event interrupt level |
| irq_error | output | 1 | Error interrupt level |

## Verification
An engine pulse and a software access that clears the same flag can land in the same cycle. The bus-error pulse with a zeroing write to status word 1 is one such pair. The address-sent pulse with the status word 2 read that completes the clear sequence is another. The bench drives each pair in a single cycle and then reads status word 1, and it expects the flag to still be set. The bench also interrupts the clear sequences with an unrelated access and expects the flags to survive.

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start_sent,
  input  logic              ev_addr_sent,
  input  logic              ev_byte_done,
  input  logic              ev_tx_empty,
  input  logic              ev_rx_full,
  input  logic              ev_ack_fail,
  input  logic              ev_arb_lost,
  input  logic              ev_bus_err,
  input  logic              bus_start_det,
  input  logic              bus_stop_det,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq_event,
  output logic              irq_error
);
  localparam logic [1:0] A_ST1 = 2'd0, A_ST2 = 2'd1, A_CTL = 2'd2, A_DAT = 2'd3;

  logic f_sb, f_addr, f_btf, f_txe, f_rxne, f_berr, f_arlo, f_af;
  logic busy, en_err, en_evt, en_buf, st1_seen;

  wire rd_st1 = reg_rd && reg_addr == A_ST1;
  wire rd_st2 = reg_rd && reg_addr == A_ST2;
  wire rd_dat = reg_rd && reg_addr == A_DAT;
  wire wr_st1 = reg_wr && reg_addr == A_ST1;
  wire wr_ctl = reg_wr && reg_addr == A_CTL;
  wire wr_dat = reg_wr && reg_addr == A_DAT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {f_sb, f_addr, f_btf, f_txe, f_rxne, f_berr, f_arlo, f_af} <= '0;
      {busy, en_err, en_evt, en_buf, st1_seen} <= '0;
      tx_byte   <= '0;
      irq_event <= 1'b0;
      irq_error <= 1'b0;
    end else begin
      if (reg_rd || reg_wr) st1_seen <= rd_st1;
      f_sb   <= ev_start_sent | (f_sb   & ~(st1_seen & wr_dat));
      f_addr <= ev_addr_sent  | (f_addr & ~(st1_seen & rd_st2));
      f_btf  <= ev_byte_done  | (f_btf  & ~(wr_dat | rd_dat));
      f_txe  <= ev_tx_empty   | (f_txe  & ~wr_dat);
      f_rxne <= ev_rx_full    | (f_rxne & ~rd_dat);
      f_berr <= ev_bus_err    | (f_berr & ~(wr_st1 & ~reg_wdata[8]));
      f_arlo <= ev_arb_lost   | (f_arlo & ~(wr_st1 & ~reg_wdata[9]));
      f_af   <= ev_ack_fail   | (f_af   & ~(wr_st1 & ~reg_wdata[10]));
      busy   <= bus_start_det | (busy & ~bus_stop_det);
      if (wr_ctl) {en_buf, en_evt, en_err} <= reg_wdata[10:8];
      if (wr_dat) tx_byte <= reg_wdata[BYTE_W-1:0];
      irq_event <= en_evt & (f_sb | f_addr | f_btf | (en_buf & (f_txe | f_rxne)));
      irq_error <= en_err & (f_berr | f_arlo | f_af);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ST1: reg_rdata = {5'd0, f_af, f_arlo, f_berr, f_txe, f_rxne, 3'd0, f_btf, f_addr, f_sb};
      A_ST2: reg_rdata = {14'd0, busy, 1'b0};
      A_CTL: reg_rdata = {5'd0, en_buf, en_evt, en_err, 8'd0};
      default: reg_rdata[BYTE_W-1:0] = rx_byte;
    endcase
  end

  assert_err_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bus_err && en_err) ##1 en_err |=> irq_error);
  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_err |=> !irq_error);
  assert_buf_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_buf && !f_sb && !f_addr && !f_btf) |=> !irq_event);
  assert_evt_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_addr_sent && en_evt) ##1 en_evt |=> irq_event);
  assert_one_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (f_af && wr_st1 && reg_wdata[10]) |=> f_af);
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |=> reg_rdata[8] || reg_addr != A_ST1 || f_berr);
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start_det && !bus_stop_det) |=> busy);
  assert_addr_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_st1 ##1 (rd_st2 && !ev_addr_sent) |=> !f_addr);
endmodule

// File: tb/tb_i2c_stat_irq.sv
module tb_i2c_stat_irq;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    logic [15:0] mask;
    string       tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic [9:0] ev = '0;
  logic [7:0] rx_byte = 8'hA5;
  logic reg_rd = 0, reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0] tx_byte;
  logic irq_event, irq_error;
  logic req = 0;
  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stat_irq dut (
    .clk(clk), .rst_n(rst_n),
    .ev_start_sent(ev[0]), .ev_addr_sent(ev[1]), .ev_byte_done(ev[2]),
    .ev_tx_empty(ev[3]), .ev_rx_full(ev[4]), .ev_ack_fail(ev[5]),
    .ev_arb_lost(ev[6]), .ev_bus_err(ev[7]),
    .bus_start_det(ev[8]), .bus_stop_det(ev[9]),
    .rx_byte(rx_byte), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_byte(tx_byte),
    .irq_event(irq_event), .irq_error(irq_error)
  );

  always @(negedge clk) begin
    if (req && q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = reg_rdata;
        1: act = {15'd0, irq_event};
        2: act = {15'd0, irq_error};
        default: act = {8'd0, tx_byte};
      endcase
      n_run++;
      if ((act & it.mask) !== (it.exp & it.mask)) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    ev = '0; reg_rd = 0; reg_wr = 0; req = 0;
  endtask

  task automatic op(input logic rd, input logic wr, input logic [1:0] a,
                    input logic [15:0] d, input logic [9:0] e);
    tick();
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d; ev = e;
  endtask

  task automatic pulse(input logic [9:0] e);
    op(0, 0, 0, 0, e);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    op(0, 1, a, d, '0);
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input logic [15:0] m, input string tag);
    item_t it;
    op(1, 0, a, 0, '0);
    it.kind = 0; it.exp = exp; it.mask = m; it.tag = tag;
    q.push_back(it);
    req = 1;
  endtask

  task automatic chk(input int kind, input logic [15:0] exp, input string tag);
    item_t it;
    tick(); tick();
    it.kind = kind; it.exp = exp; it.mask = 16'hFFFF; it.tag = tag;
    q.push_back(it);
    req = 1;
  endtask

  task automatic do_reset();
    tick(); rst_n = 0; tick(); tick(); rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(0, 16'h0000, 16'hFFFF, "R1 status1");
    rd(1, 16'h0000, 16'hFFFF, "R1 status2");
    rd(2, 16'h0000, 16'hFFFF, "R1 control");
    chk(1, 0, "R1 irq_event");
    chk(2, 0, "R1 irq_error");
    chk(3, 0, "R1 tx_byte");
    // R12 control readback
    wr(2, 16'h0700);
    rd(2, 16'h0700, 16'h0700, "R12 control readback");
    // R2 layout
    do_reset();
    pulse(10'h0FF);
    rd(0, 16'h07C7, 16'hFFFF, "R2 status1 layout");
    // R5 / R6 errors
    do_reset();
    wr(2, 16'h0100);
    pulse(10'b0000100000);
    chk(2, 1, "R5 error irq on ack fail");
    wr(0, 16'hFFFF);
    rd(0, 16'h0400, 16'hFFFF, "R6 write one keeps");
    wr(0, 16'hFBFF);
    rd(0, 16'h0000, 16'hFFFF, "R6 write zero clears");
    chk(2, 0, "R5 error irq drops");
    wr(2, 16'h0000);
    pulse(10'b0001000000);
    chk(2, 0, "R5 masked error");
    rd(0, 16'h0200, 16'h0200, "R2 arb lost bit9");
    // R3 event irq with byte finished, R9 clear by write
    do_reset();
    wr(2, 16'h0200);
    pulse(10'b0000000100);
    chk(1, 1, "R3 event irq on byte finished");
    wr(3, 16'h0011);
    rd(0, 16'h0000, 16'h0004, "R9 data write clears byte finished");
    chk(1, 0, "R3 event irq drops");
    // R4 buffer gating
    do_reset();
    wr(2, 16'h0200);
    pulse(10'b0000001000);
    chk(1, 0, "R4 TX empty without buffer enable");
    wr(2, 16'h0600);
    chk(1, 1, "R4 TX empty with buffer enable");
    wr(3, 16'h0022);
    chk(1, 0, "R9 data write clears TX empty");
    pulse(10'b0000010000);
    chk(1, 1, "R4 RX full with buffer enable");
    rd(3, 16'h00A5, 16'h00FF, "R9 data read returns rx_byte");
    chk(1, 0, "R9 data read clears RX full");
    // R7 address clear sequence
    do_reset();
    pulse(10'b0000000010);
    rd(1, 16'h0000, 16'h0002, "R7 status2 busy idle");
    rd(0, 16'h0002, 16'h0002, "R7 status2 alone keeps address");
    wr(2, 16'h0000);
    rd(1, 16'h0000, 16'h0002, "R7 status2 after other access");
    rd(0, 16'h0002, 16'h0002, "R7 broken sequence keeps address");
    rd(1, 16'h0000, 16'h0002, "R7 status2 closes sequence");
    rd(0, 16'h0000, 16'h0002, "R7 address cleared");
    // R8 start clear sequence, R12 tx_byte
    do_reset();
    pulse(10'b0000000001);
    wr(3, 16'h003C);
    rd(0, 16'h0001, 16'h0001, "R8 data write alone keeps start");
    wr(3, 16'h005A);
    rd(0, 16'h0000, 16'h0001, "R8 start cleared");
    chk(3, 16'h005A, "R12 tx_byte");
    // R10 busy
    pulse(10'b0100000000);
    rd(1, 16'h0002, 16'h0002, "R10 busy set");
    pulse(10'b1000000000);
    rd(1, 16'h0000, 16'h0002, "R10 busy cleared");
    // R11 collisions
    do_reset();
    pulse(10'b0010000000);
    op(0, 1, 0, 16'h0000, 10'b0010000000);
    rd(0, 16'h0100, 16'h0100, "R11 bus error set beats zero write");
    pulse(10'b0000000010);
    rd(0, 16'h0002, 16'h0002, "R11 address set before sequence");
    op(1, 0, 1, 0, 10'b0000000010);
    rd(0, 16'h0002, 16'h0002, "R11 address set beats sequence");
    tick(); tick();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule